// File: doc/BRIEF.md
# UART Interrupt Prioritizer with FIFO Thresholds

This block decides which interrupt a 16550-style UART with FIFOs raises and what the identification register reports. It holds the interrupt enable bits and the FIFO control settings: FIFO enable, receive trigger select and transmit empty trigger select. From these settings and the live inputs it picks the highest-priority pending cause. The live inputs are the receive and transmit FIFO fill levels, a line-status error flag, a character-timeout flag and a modem-status-change flag. The result is shown on a read-only identification byte and on one interrupt line.

The transmit-empty cause can run in a programmable mode. In that mode it fires when the transmit fill level drops to or below a selectable threshold, and not only when the FIFO runs dry. A read of the identification byte that reports the transmit-empty cause acknowledges it. The receive trigger level also sets the point at which the request-to-send output is withdrawn under automatic flow control. The FIFOs, shifters, baud divisor and bus decode sit outside this block.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset the identification byte reads 01h, the enable byte reads 00h, `irq` is low and FIFOs are disabled.
- R2: A write to the enable byte stores bits 3:0. Bits 6:4 always read as zero. Bit 7, the programmable transmit mode, is stored only when the parameter `USER_THRE_EN` is 1, and otherwise reads zero. Enable bit 0 covers receive data and timeout, bit 1 transmit empty, bit 2 line status and bit 3 modem status.
- R3: A write to FIFO control takes bit 0 as FIFO enable, bits 7:6 as receive trigger select and bits 5:4 as transmit trigger select. Identification bits 7:6 read 11 while FIFOs are enabled and 00 otherwise. Bits 5:4 read zero.
- R4: Identification bits 3:0 are 0001 with nothing pending, 0110 for line status, 0100 for receive data, 1100 for character timeout, 0010 for transmit empty and 0000 for modem status. `irq` is high exactly when bit 0 is 0.
- R5: Priority, highest first, is line status, then receive data, then character timeout, then transmit empty, then modem status.
- R6: Receive data is pending when the receive level is at or above the trigger level. Select 00 gives 1, 01 gives DEPTH/4, 10 gives DEPTH/2 and 11 gives DEPTH-2. With FIFOs disabled the trigger level is 1.
- R7: Character timeout is reported only while FIFOs are enabled and enable bit 0 is set.
- R8: The transmit-empty condition going from false to true arms a pending flag. A read of the identification byte while it reports 0010 clears the flag, and the next identification value is not 0010. The flag also drops when the condition is false.
- R9: With bit 7 of the enable byte set and FIFOs enabled, the transmit-empty condition is a level at or below the threshold. Select 00 gives 0, 01 gives 2, 10 gives DEPTH/4 and 11 gives DEPTH/2. Otherwise the condition is a level of zero.
- R10: `rts_n` is high exactly when `afc_en` is high and the receive level is at or above the receive trigger level of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable byte write strobe |
| ier_wdata | input | 8 | Enable byte write data |
| ier_rdata | output | 8 | Enable byte read value |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write data |
| iir_rd | input | 1 | Identification read strobe |
| iir_rdata | output | 8 | Identification byte |
| rx_level | input | $clog2(DEPTH+1) | Receive FIFO fill level |
| tx_level | input | $clog2(DEPTH+1) | Transmit FIFO fill level |
| line_err | input | 1 | Receiver line status error present |
| char_tmo | input | 1 | Character timeout present |
| msr_chg | input | 1 | Modem status change present |
| afc_en | input | 1 | Automatic flow control active |
| rts_n | output | 1 | High to withdraw request-to-send |
| irq | output | 1 | Interrupt line |

## Verification
The bench drives each receive trigger select one count below and at its level, including the DEPTH-2 setting. A design with an off-by-one or swapped threshold would raise receive data one character early or late. It applies receive data and timeout together to catch an inverted ordering inside the shared priority tier, and applies timeout with FIFOs off to catch a timeout that leaks out in non-FIFO mode. The transmit-empty cause is read, held, dropped and re-raised, both at the empty level and at the programmable threshold. This exposes a flag that never clears, one that re-arms without a fresh transition, and a threshold compared with the wrong sense. A second instance built without the user mode shows whether bit 7 of the enable byte is wrongly writable.

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int DEPTH = 16,
  parameter bit USER_THRE_EN = 1'b1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ier_wr,
  input  logic [7:0]    ier_wdata,
  output logic [7:0]    ier_rdata,
  input  logic          fcr_wr,
  input  logic [7:0]    fcr_wdata,
  input  logic          iir_rd,
  output logic [7:0]    iir_rdata,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic          line_err,
  input  logic          char_tmo,
  input  logic          msr_chg,
  input  logic          afc_en,
  output logic          rts_n,
  output logic          irq
);
  localparam logic [LW-1:0] LV_ONE  = LW'(1);
  localparam logic [LW-1:0] LV_TWO  = LW'(2);
  localparam logic [LW-1:0] LV_QTR  = LW'(DEPTH / 4);
  localparam logic [LW-1:0] LV_HALF = LW'(DEPTH / 2);
  localparam logic [LW-1:0] LV_NF   = LW'(DEPTH - 2);

  localparam logic [3:0] ID_NONE = 4'b0001;
  localparam logic [3:0] ID_LS   = 4'b0110;
  localparam logic [3:0] ID_RDA  = 4'b0100;
  localparam logic [3:0] ID_CTO  = 4'b1100;
  localparam logic [3:0] ID_THRE = 4'b0010;
  localparam logic [3:0] ID_MS   = 4'b0000;

  logic [3:0]    en;
  logic          ptime;
  logic          fifo_en;
  logic [1:0]    rx_sel, tx_sel;
  logic          thre_pend, thre_cond_q;
  logic [LW-1:0] rx_thr, tx_thr;
  logic          thre_cond;
  logic [3:0]    code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= '0;
      ptime   <= 1'b0;
      fifo_en <= 1'b0;
      rx_sel  <= '0;
      tx_sel  <= '0;
    end else begin
      if (ier_wr) begin
        en    <= ier_wdata[3:0];
        ptime <= USER_THRE_EN & ier_wdata[7];
      end
      if (fcr_wr) begin
        fifo_en <= fcr_wdata[0];
        rx_sel  <= fcr_wdata[7:6];
        tx_sel  <= fcr_wdata[5:4];
      end
    end
  end

  always_comb begin
    case (rx_sel)
      2'b00:   rx_thr = LV_ONE;
      2'b01:   rx_thr = LV_QTR;
      2'b10:   rx_thr = LV_HALF;
      default: rx_thr = LV_NF;
    endcase
    if (!fifo_en) rx_thr = LV_ONE;
  end

  always_comb begin
    case (tx_sel)
      2'b00:   tx_thr = '0;
      2'b01:   tx_thr = LV_TWO;
      2'b10:   tx_thr = LV_QTR;
      default: tx_thr = LV_HALF;
    endcase
  end

  assign thre_cond = (ptime && fifo_en) ? (tx_level <= tx_thr) : (tx_level == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_pend   <= 1'b0;
      thre_cond_q <= 1'b0;
    end else begin
      thre_cond_q <= thre_cond;
      if (thre_cond && !thre_cond_q)
        thre_pend <= 1'b1;
      else if (!thre_cond || (iir_rd && code == ID_THRE))
        thre_pend <= 1'b0;
    end
  end

  always_comb begin
    if (en[2] && line_err)                 code = ID_LS;
    else if (en[0] && rx_level >= rx_thr)  code = ID_RDA;
    else if (en[0] && fifo_en && char_tmo) code = ID_CTO;
    else if (en[1] && thre_pend)           code = ID_THRE;
    else if (en[3] && msr_chg)             code = ID_MS;
    else                                   code = ID_NONE;
  end

  assign iir_rdata = {{2{fifo_en}}, 2'b00, code};
  assign ier_rdata = {ptime, 3'b000, en};
  assign irq       = ~code[0];
  assign rts_n     = afc_en && (rx_level >= rx_thr);
endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk #(
  parameter bit USER_THRE_EN = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       fcr_wr,
  input logic [7:0] fcr_wdata,
  input logic       iir_rd,
  input logic [7:0] iir_rdata,
  input logic [7:0] ier_rdata,
  input logic       line_err,
  input logic       afc_en,
  input logic       rts_n,
  input logic       irq
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_id_R1: assert (iir_rdata == 8'h01 && ier_rdata == 8'h00 && !irq);
    end
  end

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ier_rdata[6:4] == 3'b000 && (USER_THRE_EN || !ier_rdata[7]));

  assert_fifo_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_wr |=> iir_rdata[7:6] == {2{$past(fcr_wdata[0])}} && iir_rdata[5:4] == 2'b00);

  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ier_rdata[3:0] == 4'h0 |-> !irq);

  assert_ls_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_rdata[2] && line_err) |-> iir_rdata[3:0] == 4'b0110);

  assert_cto_fifo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !iir_rdata[7] |-> iir_rdata[3:0] != 4'b1100);

  assert_thre_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir_rdata[3:0] == 4'b0010) |=> iir_rdata[3:0] != 4'b0010);

  assert_rts_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !afc_en |-> !rts_n);
endmodule

bind uart_irq_prio uart_irq_prio_chk #(.USER_THRE_EN(USER_THRE_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
  .iir_rd(iir_rd), .iir_rdata(iir_rdata), .ier_rdata(ier_rdata),
  .line_err(line_err), .afc_en(afc_en), .rts_n(rts_n), .irq(irq)
);

// File: tb/test_uart_irq_prio.sv
module test_uart_irq_prio;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ier_wr = 1'b0, fcr_wr = 1'b0, iir_rd = 1'b0;
  logic [7:0] ier_wdata = '0, fcr_wdata = '0;
  logic [LW-1:0] rx_level = '0, tx_level = '0;
  logic line_err = 1'b0, char_tmo = 1'b0, msr_chg = 1'b0, afc_en = 1'b0;
  logic [7:0] ier_rdata, iir_rdata, ier_rdata_lk, iir_rdata_lk;
  logic rts_n, irq, rts_n_lk, irq_lk;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [7:0] ier_model = 8'h00;

  typedef struct {
    logic [7:0] iir;
    logic       irq;
    logic       rts;
    logic [7:0] ier;
    logic [7:0] ier_lk;
    string      req;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_prio #(.DEPTH(DEPTH), .USER_THRE_EN(1'b1)) i_uart_irq_prio (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata), .ier_rdata(ier_rdata),
    .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata), .iir_rd(iir_rd), .iir_rdata(iir_rdata),
    .rx_level(rx_level), .tx_level(tx_level), .line_err(line_err), .char_tmo(char_tmo),
    .msr_chg(msr_chg), .afc_en(afc_en), .rts_n(rts_n), .irq(irq));

  uart_irq_prio #(.DEPTH(DEPTH), .USER_THRE_EN(1'b0)) i_uart_irq_prio_lk (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata), .ier_rdata(ier_rdata_lk),
    .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata), .iir_rd(iir_rd), .iir_rdata(iir_rdata_lk),
    .rx_level(rx_level), .tx_level(tx_level), .line_err(line_err), .char_tmo(char_tmo),
    .msr_chg(msr_chg), .afc_en(afc_en), .rts_n(rts_n_lk), .irq(irq_lk));

  task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check8(it.req, "iir", iir_rdata, it.iir);
        check8(it.req, "irq", {7'b0, irq}, {7'b0, it.irq});
        check8(it.req, "rts_n", {7'b0, rts_n}, {7'b0, it.rts});
        check8(it.req, "ier", ier_rdata, it.ier);
        check8(it.req, "ier_locked", ier_rdata_lk, it.ier_lk);
      end
    end
  end

  task automatic push(logic [7:0] e_iir, logic e_rts, string req);
    item_t it;
    it.iir = e_iir;
    it.irq = ~e_iir[0];
    it.rts = e_rts;
    it.ier = ier_model;
    it.ier_lk = ier_model & 8'h0F;
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic op(bit iw, logic [7:0] id, bit fw, logic [7:0] fd, bit rd,
                    int rx, int tx, bit le, bit ct, bit ms, bit afc,
                    logic [7:0] e_iir, bit e_rts, string req);
    ier_wr = iw; ier_wdata = id; fcr_wr = fw; fcr_wdata = fd; iir_rd = rd;
    rx_level = LW'(rx); tx_level = LW'(tx);
    line_err = le; char_tmo = ct; msr_chg = ms; afc_en = afc;
    @(posedge clk);
    #1;
    ier_wr = 1'b0; fcr_wr = 1'b0; iir_rd = 1'b0;
    if (iw) ier_model = id & 8'h8F;
    push(e_iir, e_rts, req);
    @(negedge clk);
    #1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (2) @(negedge clk);
    push(8'h01, 1'b0, "R1 reset");
    @(negedge clk); #1;
    rst_n = 1'b1;
    //  ier       fcr       rd  rx  tx  le ct ms afc  iir   rts
    op(0, 8'h00, 0, 8'h00, 0,  0,  0, 0, 0, 0, 0, 8'h01, 0, "R1 idle after reset");
    op(1, 8'h02, 0, 8'h00, 0,  0,  0, 0, 0, 0, 0, 8'h02, 0, "R8 thre armed by empty");
    op(0, 8'h00, 0, 8'h00, 1,  0,  0, 0, 0, 0, 0, 8'h01, 0, "R8 read clears thre");
    op(0, 8'h00, 0, 8'h00, 0,  0,  5, 0, 0, 0, 0, 8'h01, 0, "R9 nonempty no thre");
    op(0, 8'h00, 0, 8'h00, 0,  0,  0, 0, 0, 0, 0, 8'h02, 0, "R8 re-arm on new empty");
    op(0, 8'h00, 1, 8'hC1, 0,  0,  0, 0, 0, 0, 0, 8'hC2, 0, "R3 fifo enabled flag");
    op(1, 8'h03, 0, 8'h00, 0, 13,  0, 0, 0, 0, 0, 8'hC2, 0, "R6 below depth-2");
    op(0, 8'h00, 0, 8'h00, 0, 14,  0, 0, 0, 0, 0, 8'hC4, 0, "R6 at depth-2");
    op(0, 8'h00, 0, 8'h00, 0, 14,  0, 0, 1, 0, 0, 8'hC4, 0, "R5 rx data over timeout");
    op(0, 8'h00, 0, 8'h00, 0,  3,  0, 0, 1, 0, 0, 8'hCC, 0, "R7 timeout in fifo mode");
    op(1, 8'h07, 0, 8'h00, 0,  3,  0, 1, 1, 0, 0, 8'hC6, 0, "R5 line status highest");
    op(1, 8'h0F, 0, 8'h00, 0,  0,  0, 0, 0, 1, 0, 8'hC2, 0, "R5 thre over modem");
    op(0, 8'h00, 0, 8'h00, 1,  0,  0, 0, 0, 1, 0, 8'hC0, 0, "R4 modem code after ack");
    op(0, 8'h00, 1, 8'h01, 0,  1,  0, 0, 0, 0, 0, 8'hC4, 0, "R6 one char trigger");
    op(1, 8'h01, 1, 8'h00, 0,  0,  0, 0, 1, 0, 0, 8'h01, 0, "R7 timeout ignored fifo off");
    op(1, 8'h82, 1, 8'h31, 0,  0, 10, 0, 0, 0, 0, 8'hC1, 0, "R2 R9 ptime set above thr");
    op(0, 8'h00, 0, 8'h00, 0,  0,  8, 0, 0, 0, 0, 8'hC2, 0, "R9 at half threshold");
    op(0, 8'h00, 0, 8'h00, 1,  0,  8, 0, 0, 0, 0, 8'hC1, 0, "R8 ack in prog mode");
    op(0, 8'h00, 0, 8'h00, 0,  0,  9, 0, 0, 0, 0, 8'hC1, 0, "R9 above threshold");
    op(0, 8'h00, 0, 8'h00, 0,  0,  7, 0, 0, 0, 0, 8'hC2, 0, "R9 below threshold rearm");
    op(1, 8'h02, 0, 8'h00, 0,  0,  7, 0, 0, 0, 0, 8'hC2, 0, "R9 ptime cleared");
    op(0, 8'h00, 0, 8'h00, 0,  0,  7, 0, 0, 0, 0, 8'hC1, 0, "R9 only empty counts now");
    op(0, 8'h00, 0, 8'h00, 0,  0,  0, 0, 0, 0, 0, 8'hC2, 0, "R9 empty without ptime");
    op(0, 8'h00, 1, 8'h81, 0,  7,  0, 0, 0, 0, 1, 8'hC2, 0, "R10 below half keeps rts");
    op(0, 8'h00, 0, 8'h00, 0,  8,  0, 0, 0, 0, 1, 8'hC2, 1, "R10 at half drops rts");
    op(0, 8'h00, 0, 8'h00, 0,  8,  0, 0, 0, 0, 0, 8'hC2, 0, "R10 no afc");
    op(1, 8'h01, 1, 8'h41, 0,  3,  0, 0, 0, 0, 0, 8'hC1, 0, "R6 below quarter");
    op(0, 8'h00, 0, 8'h00, 0,  4,  0, 0, 0, 0, 0, 8'hC4, 0, "R6 at quarter");
    op(1, 8'hF3, 0, 8'h00, 0,  4,  0, 0, 0, 0, 0, 8'hC4, 0, "R2 reserved zero, lock");
    op(0, 8'h00, 1, 8'h00, 0,  0,  3, 0, 0, 0, 0, 8'h01, 0, "R3 fifo disabled flag");
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule